// File: doc/BRIEF.md
# PCI Status Register with Write-One-to-Clear Error Capture

This block holds the 16-bit status half-word of a PCI host bridge's configuration header. The bridge's master and parity logic reports error events on single-cycle strobes, and the block qualifies each one against its own condition. A qualified event sets a sticky bit that stays set until software writes a one to it. The block also reports a fixed device-select timing code. When it must raise a system error, it drives a one-clock system-error request.

Software reaches the register through a 32-bit configuration port with a dword address and four byte enables. The status register is the upper half of the dword at `STATUS_DW`, which is byte offsets 06h–07h. Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `pci_err_status_reg`

## Requirements
- R1: When `cfg_addr` equals `STATUS_DW`, `cfg_rdata[31:16]` carries the status word and `cfg_rdata[15:0]` is zero. Any other address reads as all zero. Status bits 15, 11 and 7:0 always read zero.
- R2: Status bit 14 (system error signaled) is set in the same clock edge that raises `serr_req`. It is cleared by a write of one.
- R3: Status bit 13 (master abort received) is set one clock after `ev_mabort` is high while `ev_special` is low. A master abort during a special cycle leaves the bit unchanged. It is cleared by a write of one.
- R4: Status bit 12 (target abort received) is set one clock after `ev_tabort`. It is cleared by a write of one.
- R5: Status bit 8 (data parity detected) is set one clock after `ev_perr`, `ev_own_master` and `perr_resp_en` are all high in the same cycle. If any one of them is low, the bit is not set. It is cleared by a write of one.
- R6: Status bits 10:9 always equal the parameter `DEVSEL_CODE` (00 fast, 01 medium, 10 slow). Writes to these bits are ignored.
- R7: `serr_req` is high for exactly the cycle after a cycle in which `ev_serr` was high, or `ev_tabort` and `serr_tabort_en` were both high. Otherwise it is low.
- R8: If a set event and a write-one-clear hit the same bit in the same cycle, the bit ends up set.
- R9: A clear requires `cfg_wr`, `cfg_addr == STATUS_DW` and `cfg_be[3]` (the byte holding bits 15:8, taken from `cfg_wdata[31:24]`). Writing zero to a bit leaves it unchanged.
- R10: After reset all sticky bits are zero and `serr_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration dword address |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| ev_mabort | input | 1 | Transaction initiated by the bridge ended in master abort |
| ev_special | input | 1 | The aborted transaction was a special cycle |
| ev_tabort | input | 1 | Transaction initiated by the bridge ended in target abort |
| ev_perr | input | 1 | PERR driven or sampled active |
| ev_own_master | input | 1 | Bridge was bus master for that operation |
| ev_serr | input | 1 | Other source requests a system error |
| perr_resp_en | input | 1 | Parity-error response enable |
| serr_tabort_en | input | 1 | System error on target abort enable |
| serr_req | output | 1 | One-clock system-error request |

## Verification
The bench drives clears in the same cycle as the matching set event. A design that lets the clear win would lose an error report. It checks a master abort with the special-cycle flag, and parity events with each qualifier dropped in turn. A design that ignores a qualifier would set a bit it must not set. It writes all ones with the upper byte enable off, at a wrong address, and over the timing field. A wrong decode would then wipe errors or corrupt the timing code. Target aborts are driven with and without the escalation enable, so a missing or stuck system-error path shows up on `serr_req` and on bit 14.

// File: rtl/pcisr_pkg.sv
package pcisr_pkg;
  localparam int NSTICKY = 4;
  localparam int SSE_B   = 14;
  localparam int RMA_B   = 13;
  localparam int RTA_B   = 12;
  localparam int DPD_B   = 8;
  localparam int DEVT_LO = 9;
  // Sticky bit positions, index order: sse, rma, rta, dpd
  localparam int STICKY_POS [NSTICKY] = '{SSE_B, RMA_B, RTA_B, DPD_B};
endpackage

// File: rtl/pcisr_event_qual.sv
module pcisr_event_qual
  import pcisr_pkg::*;
(
  input  logic               ev_mabort,
  input  logic               ev_special,
  input  logic               ev_tabort,
  input  logic               ev_perr,
  input  logic               ev_own_master,
  input  logic               ev_serr,
  input  logic               perr_resp_en,
  input  logic               serr_tabort_en,
  output logic [NSTICKY-1:0] set_vec,
  output logic               serr_now
);
  always_comb begin
    serr_now   = ev_serr | (ev_tabort & serr_tabort_en);
    set_vec[0] = serr_now;
    set_vec[1] = ev_mabort & ~ev_special;
    set_vec[2] = ev_tabort;
    set_vec[3] = ev_perr & ev_own_master & perr_resp_en;
  end
endmodule

// File: rtl/pcisr_cfg_decode.sv
module pcisr_cfg_decode
  import pcisr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int STATUS_DW = 1
) (
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic               cfg_wr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic               hit,
  output logic [NSTICKY-1:0] clr_vec
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(STATUS_DW);

  assign hit = (cfg_addr == SEL);

  for (genvar i = 0; i < NSTICKY; i++) begin : g_clr
    localparam int WB = 16 + STICKY_POS[i];
    localparam int BE = WB / 8;
    assign clr_vec[i] = cfg_wr & hit & cfg_be[BE] & cfg_wdata[WB];
  end
endmodule

// File: rtl/pcisr_sticky_bit.sv
module pcisr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set | clr;
    q_d  = set;           // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/pci_err_status_reg.sv
module pci_err_status_reg
  import pcisr_pkg::*;
#(
  parameter int         ADDR_W      = 6,
  parameter int         STATUS_DW   = 1,
  parameter logic [1:0] DEVSEL_CODE = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ev_mabort,
  input  logic              ev_special,
  input  logic              ev_tabort,
  input  logic              ev_perr,
  input  logic              ev_own_master,
  input  logic              ev_serr,
  input  logic              perr_resp_en,
  input  logic              serr_tabort_en,
  output logic              serr_req
);
  logic [NSTICKY-1:0] set_vec;
  logic [NSTICKY-1:0] clr_vec;
  logic [NSTICKY-1:0] sticky_q;
  logic               serr_now;
  logic               hit;
  logic               serr_d;
  logic [15:0]        status_q;

  pcisr_event_qual u_qual (
    .ev_mabort      (ev_mabort),
    .ev_special     (ev_special),
    .ev_tabort      (ev_tabort),
    .ev_perr        (ev_perr),
    .ev_own_master  (ev_own_master),
    .ev_serr        (ev_serr),
    .perr_resp_en   (perr_resp_en),
    .serr_tabort_en (serr_tabort_en),
    .set_vec        (set_vec),
    .serr_now       (serr_now)
  );

  pcisr_cfg_decode #(.ADDR_W(ADDR_W), .STATUS_DW(STATUS_DW)) u_dec (
    .cfg_addr  (cfg_addr),
    .cfg_wr    (cfg_wr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .hit       (hit),
    .clr_vec   (clr_vec)
  );

  for (genvar i = 0; i < NSTICKY; i++) begin : g_bit
    pcisr_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_vec[i]),
      .clr   (clr_vec[i]),
      .q     (sticky_q[i])
    );
  end

  // system-error request: next state, then register
  always_comb serr_d = serr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_req <= 1'b0;
    else        serr_req <= serr_d;
  end

  always_comb begin
    status_q = '0;
    for (int i = 0; i < NSTICKY; i++) status_q[STICKY_POS[i]] = sticky_q[i];
    status_q[DEVT_LO +: 2] = DEVSEL_CODE;
  end

  assign cfg_rdata = hit ? {status_q, 16'h0000} : 32'h0;
endmodule

// File: rtl/pcisr_chk.sv
module pcisr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] status,
  input logic        serr_req,
  input logic        cfg_wr,
  input logic        hit,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        ev_mabort,
  input logic        ev_special,
  input logic        ev_tabort,
  input logic        ev_perr,
  input logic        ev_own_master,
  input logic        ev_serr,
  input logic        perr_resp_en,
  input logic        serr_tabort_en
);
  AST_SERR_MARKS_SSE: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> status[14]); // R2
  AST_MABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mabort && !ev_special) |=> status[13]); // R3
  AST_RMA_ROSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[13]) |-> $past(ev_mabort && !ev_special)); // R3
  AST_TABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tabort |=> status[12]); // R4
  AST_DPD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_perr && ev_own_master && perr_resp_en) |=> status[8]); // R5
  AST_DPD_ROSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[8]) |-> $past(ev_perr && ev_own_master && perr_resp_en)); // R5
  AST_SERR_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_serr || (ev_tabort && serr_tabort_en)) |=> serr_req); // R7
  AST_SERR_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_serr || (ev_tabort && serr_tabort_en)) |=> !serr_req); // R7
  AST_RTA_FELL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[12]) |-> $past(cfg_wr && hit && cfg_be[3] && cfg_wdata[28])); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] == 1'b0 && status[11] == 1'b0 && status[7:0] == 8'h00); // R1
endmodule

bind pci_err_status_reg pcisr_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .status         (status_q),
  .serr_req       (serr_req),
  .cfg_wr         (cfg_wr),
  .hit            (hit),
  .cfg_be         (cfg_be),
  .cfg_wdata      (cfg_wdata),
  .ev_mabort      (ev_mabort),
  .ev_special     (ev_special),
  .ev_tabort      (ev_tabort),
  .ev_perr        (ev_perr),
  .ev_own_master  (ev_own_master),
  .ev_serr        (ev_serr),
  .perr_resp_en   (perr_resp_en),
  .serr_tabort_en (serr_tabort_en)
);

// File: tb/sim_pci_err_status_reg.sv
`timescale 1ns/1ps
module sim_pci_err_status_reg;
  localparam int         AW   = 6;
  localparam int         SDW  = 1;
  localparam logic [1:0] DEVT = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic ev_mabort = 0, ev_special = 0, ev_tabort = 0, ev_perr = 0;
  logic ev_own_master = 0, ev_serr = 0, perr_resp_en = 0, serr_tabort_en = 0;
  logic serr_req;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pci_err_status_reg #(.ADDR_W(AW), .STATUS_DW(SDW), .DEVSEL_CODE(DEVT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_mabort(ev_mabort), .ev_special(ev_special), .ev_tabort(ev_tabort),
    .ev_perr(ev_perr), .ev_own_master(ev_own_master), .ev_serr(ev_serr),
    .perr_resp_en(perr_resp_en), .serr_tabort_en(serr_tabort_en),
    .serr_req(serr_req)
  );

  // behavioural reference model
  bit m_sse, m_rma, m_rta, m_dpd, m_serr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sse = 0; m_rma = 0; m_rta = 0; m_dpd = 0; m_serr = 0;
    end else begin
      bit cause_serr;
      bit wr_ok;
      cause_serr = ev_serr || (ev_tabort && serr_tabort_en);
      wr_ok = cfg_wr && (int'(cfg_addr) == SDW) && cfg_be[3];
      if (wr_ok) begin
        if (cfg_wdata[30]) m_sse = 0;
        if (cfg_wdata[29]) m_rma = 0;
        if (cfg_wdata[28]) m_rta = 0;
        if (cfg_wdata[24]) m_dpd = 0;
      end
      if (cause_serr) m_sse = 1;
      if (ev_mabort && !ev_special) m_rma = 1;
      if (ev_tabort) m_rta = 1;
      if (ev_perr && ev_own_master && perr_resp_en) m_dpd = 1;
      m_serr = cause_serr;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (int'(cfg_addr) == SDW) begin
        chk("R2 sse",  32'(cfg_rdata[30]), 32'(m_sse));
        chk("R3 rma",  32'(cfg_rdata[29]), 32'(m_rma));
        chk("R4 rta",  32'(cfg_rdata[28]), 32'(m_rta));
        chk("R5 dpd",  32'(cfg_rdata[24]), 32'(m_dpd));
        chk("R6 devt", 32'(cfg_rdata[26:25]), 32'(DEVT));
        chk("R1 rsvd", {16'h0, cfg_rdata[31], cfg_rdata[27], cfg_rdata[23:16], cfg_rdata[15:0]}, 32'h0);
      end else begin
        chk("R1 other addr", cfg_rdata, 32'h0);
      end
      chk("R7 serr_req", 32'(serr_req), 32'(m_serr));
    end
  end

  task automatic idle();
    cfg_wr = 0; cfg_be = 0; cfg_wdata = 0; cfg_addr = AW'(SDW);
    ev_mabort = 0; ev_special = 0; ev_tabort = 0; ev_perr = 0;
    ev_own_master = 0; ev_serr = 0;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr_clr(logic [3:0] be, logic [31:0] d, logic [AW-1:0] a);
    cfg_wr = 1; cfg_be = be; cfg_wdata = d; cfg_addr = a;
  endtask

  initial begin
    int limit = 100000;
    repeat (limit) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R10 reset state
    chk("R10 reset status", cfg_rdata, {5'b0, DEVT, 25'b0});
    chk("R10 reset serr", 32'(serr_req), 0);

    // R3 special-cycle master abort ignored
    ev_mabort = 1; ev_special = 1; step(); idle(); step();
    chk("R3 special ignored", 32'(cfg_rdata[29]), 0);
    ev_mabort = 1; step(); idle(); step();
    chk("R3 mabort set", 32'(cfg_rdata[29]), 1);

    // R5 each qualifier dropped
    ev_perr = 1; ev_own_master = 1; perr_resp_en = 0; step(); idle(); step();
    chk("R5 no enable", 32'(cfg_rdata[24]), 0);
    ev_perr = 1; perr_resp_en = 1; step(); idle(); step();
    chk("R5 not master", 32'(cfg_rdata[24]), 0);
    ev_own_master = 1; step(); idle(); step();
    chk("R5 no perr", 32'(cfg_rdata[24]), 0);
    ev_perr = 1; ev_own_master = 1; step(); idle(); step();
    chk("R5 all three", 32'(cfg_rdata[24]), 1);

    // R4 target abort without escalation
    serr_tabort_en = 0; ev_tabort = 1; step(); idle();
    chk("R7 no escalation", 32'(serr_req), 0);
    step();
    chk("R4 rta set", 32'(cfg_rdata[28]), 1);
    chk("R2 sse still 0", 32'(cfg_rdata[30]), 0);

    // R9 clears blocked by byte enable, address, zero data
    wr_clr(4'b0111, 32'hFFFF_FFFF, AW'(SDW)); step(); idle(); step();
    chk("R9 be3 off", 32'(cfg_rdata[29:28]), 3);
    wr_clr(4'b1111, 32'hFFFF_FFFF, AW'(SDW + 1)); step(); idle(); step();
    chk("R9 wrong addr", 32'(cfg_rdata[29:28]), 3);
    wr_clr(4'b1111, 32'h0000_0000, AW'(SDW)); step(); idle(); step();
    chk("R9 write zero", 32'(cfg_rdata[29:28]), 3);
    // R6 write over timing field
    wr_clr(4'b1111, 32'h0600_0000, AW'(SDW)); step(); idle(); step();
    chk("R6 devt kept", 32'(cfg_rdata[26:25]), 32'(DEVT));

    // R8 set wins over same-cycle clear
    wr_clr(4'b1000, 32'h1000_0000, AW'(SDW)); ev_tabort = 1; step(); idle(); step();
    chk("R8 set wins", 32'(cfg_rdata[28]), 1);
    wr_clr(4'b1000, 32'h1000_0000, AW'(SDW)); step(); idle(); step();
    chk("R4 rta cleared", 32'(cfg_rdata[28]), 0);

    // R7 / R2 escalation
    serr_tabort_en = 1; ev_tabort = 1; step(); idle();
    chk("R7 escalated pulse", 32'(serr_req), 1);
    step();
    chk("R7 pulse ends", 32'(serr_req), 0);
    chk("R2 sse set", 32'(cfg_rdata[30]), 1);
    wr_clr(4'b1000, 32'h4000_0000, AW'(SDW)); step(); idle(); step();
    chk("R2 sse cleared", 32'(cfg_rdata[30]), 0);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      idle();
      ev_mabort      = ($urandom % 8) == 0;
      ev_special     = ($urandom % 3) == 0;
      ev_tabort      = ($urandom % 8) == 0;
      ev_perr        = ($urandom % 6) == 0;
      ev_own_master  = ($urandom % 2) == 0;
      ev_serr        = ($urandom % 12) == 0;
      perr_resp_en   = ($urandom % 4) != 0;
      serr_tabort_en = ($urandom % 2) == 0;
      if (($urandom % 3) == 0)
        wr_clr(4'($urandom), $urandom, (($urandom % 4) == 0) ? AW'(SDW + 2) : AW'(SDW));
      else if (($urandom % 5) == 0)
        cfg_addr = AW'($urandom);
      step();
    end
    idle(); step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule